// File: doc/BRIEF.md
# LIN Frame Slot Controller

This block runs one node's share of a LIN frame slot on a single-wire bit stream that is timed by an external one-tick-per-bit strobe. A master-header command sends the header: a long dominant break, the 0x55 synchronisation byte and the protected identifier. A response command either sends a block of data bytes followed by their checksum, or receives a block of data bytes and checks the checksum that follows them. All serial fields are framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit.

A two-bit mode input is captured with each accepted command and picks one of four behaviours. Mode 0 is standard operation. Mode 1 drops the checksum field. Mode 2 turns off the response timeout. Mode 3 makes the node listen to itself. While a commanded phase is in progress the busy output is high. Each phase ends with a one-cycle status pulse: identifier done, transmit done, receive done or timeout.

Top module: `lin_frame_ctrl`

## Requirements
- R1: After reset, tx_line is 1, busy is 0, and id_done, tx_done, rx_done, cks_err and tout are all 0. The mode register resets to 0.
- R2: Command code 1 (header) puts the following on tx_line: exactly BRK_BITS (13) low bit times, then at least one high bit, then byte 0x55, then the protected identifier. The identifier byte holds the 6-bit id in bits 5:0, bit 6 = id0^id1^id2^id4 and bit 7 = ~(id1^id3^id4^id5). Every byte goes out as start 0, data bits LSB first, stop 1.
- R3: busy is 1 from the clock cycle after an accepted command until the cycle in which that phase's completion pulse is high. In that cycle busy is 0. For a header, the completion pulse is id_done.
- R4: Command code 2 (transmit response) sends data_len bytes from tx_bytes, with byte k taken from bits 8k+7:8k. In mode 0 a checksum byte follows: the inverted 8-bit sum of the data bytes, where each carry out of bit 7 is added back in. tx_done then pulses.
- R5: Command code 3 (receive response) samples rx_line once per tick. It stores data_len bytes into rx_bytes (byte k in bits 8k+7:8k) and then takes in a checksum byte. rx_done pulses at the end of the checksum byte. In the same cycle cks_err is 1 exactly when the received checksum differs from the expected checksum.
- R6: In mode 1 no checksum byte is sent, and on receive rx_done pulses right after the last data byte with cks_err 0.
- R7: In modes 0, 1 and 3, a response that has not completed within 14*(data_len+1) ticks of the command ends with a tout pulse. busy falls in that cycle and rx_done is not given. The count starts with the first tick after the command cycle.
- R8: In mode 2 there is no timeout. A response that arrives later than the R7 limit still completes with rx_done.
- R9: In mode 3, tx_line stays 1 and the receiver listens to the internal transmit stream instead of rx_line. A header still completes with id_done. Bytes on rx_line are ignored, so a receive response times out.
- R10: Command code 0 has no effect. A command issued while busy is 1 is ignored: it puts nothing on tx_line and gives no status pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| mode | input | 2 | Behaviour select, captured with each accepted command |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | 0 none, 1 header, 2 transmit response, 3 receive response |
| frame_id | input | 6 | Identifier for the header |
| data_len | input | LW | Response byte count, 1 to MAX_BYTES |
| tx_bytes | input | 8*MAX_BYTES | Bytes to transmit, byte k in bits 8k+7:8k |
| rx_line | input | 1 | Serial input from the bus |
| tx_line | output | 1 | Serial output to the bus, 1 when idle |
| busy | output | 1 | A commanded phase is in progress |
| id_done | output | 1 | Header finished |
| tx_done | output | 1 | Transmit response finished |
| rx_done | output | 1 | Receive response finished |
| cks_err | output | 1 | Checksum mismatch, valid with rx_done |
| tout | output | 1 | Response timed out |
| rx_bytes | output | 8*MAX_BYTES | Received bytes, byte k in bits 8k+7:8k |

## Verification
Headers are sent with a directed identifier and with random identifiers. Comparing the decoded identifier byte against the bench's own parity function separates the two parity bits from the id bits. Transmit responses use random lengths and contents, plus an all-0xFF block that forces the end-around carry on every addition and so exposes a checksum built without it. Receive responses are driven with a correct checksum and with a corrupted one, with a truncated response and with a late response. In this way timeout, no-timeout and checksum-suppressed behaviour each give a different status pulse or byte count. Commands issued while the block is busy, and listening mode, are checked at tx_line, where a wrongly accepted or wrongly driven field would show up as an extra break or extra bytes.

// File: rtl/lin_fc_pkg.sv
package lin_fc_pkg;

  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_HDR  = 2'd1;
  localparam logic [1:0] OP_TXR  = 2'd2;
  localparam logic [1:0] OP_RXR  = 2'd3;

  localparam logic [1:0] MODE_STD    = 2'd0;
  localparam logic [1:0] MODE_NOCKS  = 2'd1;
  localparam logic [1:0] MODE_NOTOUT = 2'd2;
  localparam logic [1:0] MODE_LISTEN = 2'd3;

  localparam logic [7:0] SYNC_BYTE = 8'h55;

  typedef enum logic [2:0] {
    S_IDLE, S_BRK, S_SYNC, S_PID, S_TXD, S_TXC, S_RXD, S_RXC
  } seq_e;

  // identifier with its two parity bits on top
  function automatic logic [7:0] prot_id(input logic [5:0] id);
    logic p_lo, p_hi;
    p_lo = id[0] ^ id[1] ^ id[2] ^ id[4];
    p_hi = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p_hi, p_lo, id};
  endfunction

  // 8-bit add with the carry folded back in
  function automatic logic [7:0] csum_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_tx_ser.sv
module lin_tx_ser #(
  parameter int BRK_BITS = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic       brk,
  input  logic [7:0] din,
  output logic       line,
  output logic       done
);
  localparam int SW = BRK_BITS + 1;
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          act;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      cnt  <= '0;
      act  <= 1'b0;
      line <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        act <= 1'b1;
        if (brk) begin
          sh  <= {1'b1, {BRK_BITS{1'b0}}};
          cnt <= CW'(SW);
        end else begin
          sh  <= {{(SW-10){1'b1}}, 1'b1, din, 1'b0};
          cnt <= CW'(10);
        end
      end else if (tick) begin
        if (cnt != '0) begin
          line <= sh[0];
          sh   <= {1'b1, sh[SW-1:1]};
          cnt  <= cnt - 1'b1;
        end else if (act) begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // every field ends on a recessive bit
  AST_TX_END_HIGH: assert property (@(posedge clk) disable iff (rst) done |-> line) else $error("AST_TX_END_HIGH"); // R2

endmodule

// File: rtl/lin_rx_des.sv
module lin_rx_des (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       rxi,
  output logic       byte_ok,
  output logic [7:0] q
);
  logic       act;
  logic [3:0] cnt;
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      q       <= '0;
      byte_ok <= 1'b0;
    end else if (!en) begin
      act     <= 1'b0;
      cnt     <= '0;
      byte_ok <= 1'b0;
    end else begin
      byte_ok <= 1'b0;
      if (tick) begin
        if (!act) begin
          if (!rxi) begin
            act <= 1'b1;
            cnt <= '0;
          end
        end else if (cnt < 4'd8) begin
          sh  <= {rxi, sh[7:1]};
          cnt <= cnt + 1'b1;
        end else begin
          act <= 1'b0;
          if (rxi) begin
            q       <= sh;
            byte_ok <= 1'b1;
          end
        end
      end
    end
  end

  AST_RX_ON_TICK: assert property (@(posedge clk) disable iff (rst) byte_ok |-> $past(tick) && $past(rxi)) else $error("AST_RX_ON_TICK"); // R5

endmodule

// File: rtl/lin_tout.sv
module lin_tout #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (tick && cnt != limit) begin
        cnt <= cnt + 1'b1;
        if (cnt == limit - 1'b1) expire <= 1'b1;
      end
    end
  end

  AST_TOUT_BOUND: assert property (@(posedge clk) disable iff (rst) run |-> cnt <= limit) else $error("AST_TOUT_BOUND"); // R7

endmodule

// File: rtl/lin_frame_ctrl.sv
module lin_frame_ctrl #(
  parameter int MAX_BYTES     = 8,
  parameter int BRK_BITS      = 13,
  parameter int TOUT_PER_BYTE = 14,
  localparam int LW = $clog2(MAX_BYTES + 1),
  localparam int BW = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic [1:0]    mode,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  input  logic [5:0]    frame_id,
  input  logic [LW-1:0] data_len,
  input  logic [BW-1:0] tx_bytes,
  input  logic          rx_line,
  output logic          tx_line,
  output logic          busy,
  output logic          id_done,
  output logic          tx_done,
  output logic          rx_done,
  output logic          cks_err,
  output logic          tout,
  output logic [BW-1:0] rx_bytes
);
  import lin_fc_pkg::*;

  localparam int TW = $clog2(TOUT_PER_BYTE * (MAX_BYTES + 1) + 1);

  seq_e          st;
  logic [1:0]    mode_q;
  logic [5:0]    id_q;
  logic [LW-1:0] len_q, idx, nxt_idx;
  logic [BW-1:0] txb_q;
  logic [7:0]    sum, nxt_byte, ld_byte;
  logic          ld, ld_brk;
  logic          ser_line, ser_done;
  logic          rx_ok;
  logic [7:0]    rx_q;
  logic          tmo, tmo_run, rx_en, rxi, accept, last;
  logic [TW-1:0] tlim;

  assign accept   = (st == S_IDLE) && cmd_valid && (cmd != OP_NONE);
  assign nxt_idx  = idx + 1'b1;
  assign nxt_byte = txb_q[8*nxt_idx +: 8];
  assign last     = (idx == len_q - 1'b1);
  assign tlim     = TW'(TOUT_PER_BYTE * (32'(len_q) + 1));
  assign tmo_run  = (st == S_TXD || st == S_TXC || st == S_RXD || st == S_RXC) &&
                    (mode_q != MODE_NOTOUT);
  assign rx_en    = (st == S_RXD) || (st == S_RXC);
  assign rxi      = (mode_q == MODE_LISTEN) ? ser_line : rx_line;

  lin_tx_ser #(.BRK_BITS(BRK_BITS)) u_ser (
    .clk(clk), .rst(rst), .tick(baud_tick), .load(ld), .brk(ld_brk),
    .din(ld_byte), .line(ser_line), .done(ser_done)
  );

  lin_rx_des u_des (
    .clk(clk), .rst(rst), .tick(baud_tick), .en(rx_en), .rxi(rxi),
    .byte_ok(rx_ok), .q(rx_q)
  );

  lin_tout #(.TW(TW)) u_tout (
    .clk(clk), .rst(rst), .tick(baud_tick), .run(tmo_run), .limit(tlim),
    .expire(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_line <= 1'b1;
    else     tx_line <= (mode_q == MODE_LISTEN) ? 1'b1 : ser_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mode_q   <= MODE_STD;
      id_q     <= '0;
      len_q    <= '0;
      txb_q    <= '0;
      idx      <= '0;
      sum      <= '0;
      ld       <= 1'b0;
      ld_brk   <= 1'b0;
      ld_byte  <= '0;
      busy     <= 1'b0;
      id_done  <= 1'b0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      cks_err  <= 1'b0;
      tout     <= 1'b0;
      rx_bytes <= '0;
    end else begin
      ld      <= 1'b0;
      id_done <= 1'b0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      cks_err <= 1'b0;
      tout    <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          mode_q <= mode;
          id_q   <= frame_id;
          len_q  <= data_len;
          txb_q  <= tx_bytes;
          idx    <= '0;
          busy   <= 1'b1;
          case (cmd)
            OP_HDR: begin
              st     <= S_BRK;
              ld     <= 1'b1;
              ld_brk <= 1'b1;
            end
            OP_TXR: begin
              st      <= S_TXD;
              ld      <= 1'b1;
              ld_brk  <= 1'b0;
              ld_byte <= tx_bytes[7:0];
              sum     <= tx_bytes[7:0];
            end
            default: begin
              st       <= S_RXD;
              sum      <= '0;
              rx_bytes <= '0;
            end
          endcase
        end
        S_BRK: if (ser_done) begin
          st      <= S_SYNC;
          ld      <= 1'b1;
          ld_brk  <= 1'b0;
          ld_byte <= SYNC_BYTE;
        end
        S_SYNC: if (ser_done) begin
          st      <= S_PID;
          ld      <= 1'b1;
          ld_byte <= prot_id(id_q);
        end
        S_PID: if (ser_done) begin
          st      <= S_IDLE;
          busy    <= 1'b0;
          id_done <= 1'b1;
        end
        S_TXD: if (tmo) begin
          st   <= S_IDLE;
          busy <= 1'b0;
          tout <= 1'b1;
        end else if (ser_done) begin
          if (last) begin
            if (mode_q == MODE_NOCKS) begin
              st      <= S_IDLE;
              busy    <= 1'b0;
              tx_done <= 1'b1;
            end else begin
              st      <= S_TXC;
              ld      <= 1'b1;
              ld_byte <= ~sum;
            end
          end else begin
            idx     <= nxt_idx;
            ld      <= 1'b1;
            ld_byte <= nxt_byte;
            sum     <= csum_add(sum, nxt_byte);
          end
        end
        S_TXC: if (tmo) begin
          st   <= S_IDLE;
          busy <= 1'b0;
          tout <= 1'b1;
        end else if (ser_done) begin
          st      <= S_IDLE;
          busy    <= 1'b0;
          tx_done <= 1'b1;
        end
        S_RXD: if (tmo) begin
          st   <= S_IDLE;
          busy <= 1'b0;
          tout <= 1'b1;
        end else if (rx_ok) begin
          rx_bytes[8*idx +: 8] <= rx_q;
          sum <= csum_add(sum, rx_q);
          if (last) begin
            if (mode_q == MODE_NOCKS) begin
              st      <= S_IDLE;
              busy    <= 1'b0;
              rx_done <= 1'b1;
            end else begin
              st <= S_RXC;
            end
          end else begin
            idx <= nxt_idx;
          end
        end
        S_RXC: if (tmo) begin
          st   <= S_IDLE;
          busy <= 1'b0;
          tout <= 1'b1;
        end else if (rx_ok) begin
          st      <= S_IDLE;
          busy    <= 1'b0;
          rx_done <= 1'b1;
          cks_err <= (rx_q != ~sum);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid && cmd != OP_NONE) |=> busy) else $error("AST_BUSY_ON_CMD"); // R3
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (id_done || tx_done || rx_done || tout)) else $error("AST_BUSY_FALL"); // R3
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
    $onehot0({id_done, tx_done, rx_done, tout})) else $error("AST_ONE_STATUS"); // R4
  AST_NOCKS_SKIP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NOCKS) |-> (st != S_TXC && st != S_RXC)) else $error("AST_NOCKS_SKIP"); // R6
  AST_NO_TOUT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NOTOUT) |-> !tout) else $error("AST_NO_TOUT"); // R8
  AST_LISTEN_PIN: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LISTEN && $past(mode_q) == MODE_LISTEN) |-> tx_line) else $error("AST_LISTEN_PIN"); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(id_q) && $stable(len_q) && $stable(mode_q))) else $error("AST_BUSY_IGNORE"); // R10

endmodule

// File: tb/tb_lin_frame_ctrl.sv
module tb_lin_frame_ctrl;
  localparam int MB = 8;
  localparam int LW = $clog2(MB + 1);
  localparam int BT = 4;

  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0;
  logic [1:0] mode = 2'd0, cmd = 2'd0;
  logic cmd_valid = 1'b0, rx_line = 1'b1;
  logic [5:0] frame_id = '0;
  logic [LW-1:0] data_len = '0;
  logic [8*MB-1:0] tx_bytes = '0, rx_bytes;
  logic tx_line, busy, id_done, tx_done, rx_done, cks_err, tout;

  int nchk = 0, nerr = 0, tcnt = 0;

  lin_frame_ctrl #(.MAX_BYTES(MB)) dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .mode(mode), .cmd_valid(cmd_valid),
    .cmd(cmd), .frame_id(frame_id), .data_len(data_len), .tx_bytes(tx_bytes),
    .rx_line(rx_line), .tx_line(tx_line), .busy(busy), .id_done(id_done),
    .tx_done(tx_done), .rx_done(rx_done), .cks_err(cks_err), .tout(tout),
    .rx_bytes(rx_bytes)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tcnt      <= (tcnt == BT-1) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == BT-1);
  end

  // serial decoder on tx_line, sampled two cycles after each tick
  logic [7:0] got [0:255];
  int ngot = 0, nbrk = 0, brk_len = 0, lows = 0, stop_err = 0;
  logic tk1 = 1'b0, tk2 = 1'b0, dact = 1'b0, dbrk = 1'b0, dall0 = 1'b0;
  int dn = 0, dz = 0;
  logic [7:0] dsh = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!tx_line) lows++;
      if (tk2) begin
        if (dbrk) begin
          if (!tx_line) dz++;
          else begin dbrk = 1'b0; brk_len = dz; nbrk++; end
        end else if (!dact) begin
          if (!tx_line) begin dact = 1'b1; dn = 0; dall0 = 1'b1; end
        end else begin
          dn++;
          if (dn <= 8) begin
            dsh = {tx_line, dsh[7:1]};
            if (tx_line) dall0 = 1'b0;
          end else begin
            dact = 1'b0;
            if (tx_line) begin got[ngot % 256] = dsh; ngot++; end
            else if (dall0) begin dbrk = 1'b1; dz = 10; end
            else stop_err++;
          end
        end
      end
    end
    tk2 = tk1;
    tk1 = baud_tick;
  end

  function automatic logic [7:0] exp_pid(input logic [5:0] id);
    logic a, b;
    a = id[0] ^ id[1] ^ id[2] ^ id[4];
    b = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {b, a, id};
  endfunction

  function automatic logic [7:0] exp_cks(input logic [8*MB-1:0] v, input int n);
    int s;
    s = 0;
    for (int k = 0; k < n; k++) begin
      s = s + int'(v[8*k +: 8]);
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [5:0] id, input int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; frame_id = id; data_len = LW'(n);
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 2'd0;
  endtask

  // which: 1 id_done, 2 tx_done, 3 rx_done, 4 tout, 0 nothing
  task automatic wait_end(output int which, output int ticks, output int bbad,
                          output logic ce, output logic [8*MB-1:0] rb);
    which = 0; ticks = 0; bbad = 0; ce = 1'b0; rb = '0;
    for (int i = 0; i < 20000; i++) begin
      if (baud_tick) ticks++;
      if (id_done | tx_done | rx_done | tout) begin
        which = id_done ? 1 : tx_done ? 2 : rx_done ? 3 : 4;
        ce = cks_err; rb = rx_bytes;
        if (busy) bbad++;
        break;
      end
      if (!busy) bbad++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!baud_tick);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 10; i++) begin
      do @(negedge clk); while (!baud_tick);
      rx_line = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
    end
  endtask

  task automatic send_block(input logic [8*MB-1:0] v, input int n, input bit with_cks,
                            input logic [7:0] cks, input int delay);
    wait_ticks(delay);
    for (int k = 0; k < n; k++) send_byte(v[8*k +: 8]);
    if (with_cks) send_byte(cks);
    wait_ticks(2);
  endtask

  task automatic run_hdr(input logic [5:0] id);
    int which, ticks, bbad, base, bb;
    logic ce;
    logic [8*MB-1:0] rb;
    mode = 2'd0; base = ngot; bb = nbrk;
    issue(2'd1, id, 1);
    wait_end(which, ticks, bbad, ce, rb);
    wait_ticks(3);
    chk(which == 1, "R3", "header ends with id_done", which, 1);
    chk(bbad == 0, "R3", "busy window over header", bbad, 0);
    chk(nbrk == bb + 1 && brk_len == 13, "R2", "break length", brk_len, 13);
    chk(ngot == base + 2, "R2", "header byte count", ngot - base, 2);
    chk(got[base % 256] == 8'h55, "R2", "sync byte", got[base % 256], 8'h55);
    chk(got[(base+1) % 256] == exp_pid(id), "R2", "protected id", got[(base+1) % 256], exp_pid(id));
  endtask

  task automatic run_txr(input logic [1:0] md, input logic [8*MB-1:0] v, input int n);
    int which, ticks, bbad, base, exp_n;
    logic ce;
    logic [8*MB-1:0] rb;
    mode = md; tx_bytes = v; base = ngot;
    exp_n = (md == 2'd1) ? n : n + 1;
    issue(2'd2, 6'd0, n);
    wait_end(which, ticks, bbad, ce, rb);
    wait_ticks(3);
    chk(which == 2, "R4", "tx response ends with tx_done", which, 2);
    chk(bbad == 0, "R3", "busy window over tx response", bbad, 0);
    chk(ngot == base + exp_n, (md == 2'd1) ? "R6" : "R4", "tx byte count", ngot - base, exp_n);
    for (int k = 0; k < n; k++)
      chk(got[(base+k) % 256] == v[8*k +: 8], "R4", "tx data byte", got[(base+k) % 256], v[8*k +: 8]);
    if (md != 2'd1)
      chk(got[(base+n) % 256] == exp_cks(v, n), "R4", "tx checksum", got[(base+n) % 256], exp_cks(v, n));
  endtask

  task automatic run_rxr(input logic [1:0] md, input logic [8*MB-1:0] v, input int n,
                         input bit bad_cks, input int delay);
    int which, ticks, bbad;
    logic ce;
    logic [8*MB-1:0] rb, expv;
    logic [7:0] ck;
    mode = md;
    ck = exp_cks(v, n) ^ (bad_cks ? 8'h10 : 8'h00);
    expv = '0;
    for (int k = 0; k < n; k++) expv[8*k +: 8] = v[8*k +: 8];
    issue(2'd3, 6'd0, n);
    fork
      send_block(v, n, md != 2'd1, ck, delay);
      wait_end(which, ticks, bbad, ce, rb);
    join
    chk(which == 3, (md == 2'd2) ? "R8" : "R5", "rx ends with rx_done", which, 3);
    chk(bbad == 0, "R3", "busy window over rx response", bbad, 0);
    chk(rb == expv, (md == 2'd1) ? "R6" : "R5", "rx bytes", rb, expv);
    chk(ce == bad_cks, (md == 2'd1) ? "R6" : "R5", "cks_err", ce, bad_cks);
  endtask

  function automatic logic [8*MB-1:0] rnd_bytes();
    logic [8*MB-1:0] v;
    for (int k = 0; k < MB; k++) v[8*k +: 8] = 8'($urandom);
    return v;
  endfunction

  initial begin
    int which, ticks, bbad, base, bb, lw, n;
    logic ce;
    logic [8*MB-1:0] rb, v;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_line == 1'b1, "R1", "tx_line in reset", tx_line, 1);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk({id_done, tx_done, rx_done, cks_err, tout} == 5'd0, "R1", "status in reset",
        {id_done, tx_done, rx_done, cks_err, tout}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && tx_line == 1'b1, "R1", "idle after reset", {busy, tx_line}, 1);

    // R2 R3 headers
    run_hdr(6'h3C);
    for (int i = 0; i < 4; i++) run_hdr(6'($urandom));

    // R4 transmit responses
    run_txr(2'd0, {MB{8'hFF}}, MB);
    run_txr(2'd0, 64'h0000_0000_0000_0080, 1);
    for (int i = 0; i < 4; i++) run_txr(2'd0, rnd_bytes(), 1 + int'($urandom % MB));

    // R5 receive responses
    for (int i = 0; i < 3; i++) run_rxr(2'd0, rnd_bytes(), 1 + int'($urandom % MB), 1'b0, 0);
    run_rxr(2'd0, rnd_bytes(), 3, 1'b1, 0);

    // R6 checksum suppressed
    run_txr(2'd1, rnd_bytes(), 3);
    run_rxr(2'd1, rnd_bytes(), 2, 1'b0, 0);

    // R7 truncated response times out
    mode = 2'd0; v = rnd_bytes();
    issue(2'd3, 6'd0, 2);
    fork
      send_block(v, 1, 1'b0, 8'h00, 0);
      wait_end(which, ticks, bbad, ce, rb);
    join
    chk(which == 4, "R7", "truncated rx gives tout", which, 4);
    chk(ticks == 42, "R7", "timeout tick count", ticks, 42);
    chk(bbad == 0, "R7", "busy falls with tout", bbad, 0);

    // R8 no timeout, late response completes
    run_rxr(2'd2, rnd_bytes(), 2, 1'b0, 50);

    // R9 listening mode header: pin stays high
    mode = 2'd3; base = ngot; bb = nbrk; lw = lows;
    issue(2'd1, 6'h15, 1);
    wait_end(which, ticks, bbad, ce, rb);
    wait_ticks(3);
    chk(which == 1, "R9", "listen header id_done", which, 1);
    chk(lows == lw && ngot == base && nbrk == bb, "R9", "tx_line held high", lows - lw, 0);
    // R9 external bytes ignored in listening mode
    n = 2; v = rnd_bytes();
    issue(2'd3, 6'd0, n);
    fork
      send_block(v, n, 1'b1, exp_cks(v, n), 0);
      wait_end(which, ticks, bbad, ce, rb);
    join
    chk(which == 4, "R9", "listen rx ignores rx_line", which, 4);

    // R10 command code 0 does nothing
    mode = 2'd0; lw = lows;
    issue(2'd0, 6'h01, 1);
    bbad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || id_done || tx_done || rx_done || tout) bbad++;
    end
    chk(bbad == 0 && lows == lw, "R10", "no-op command", bbad, 0);

    // R10 header issued while busy is ignored
    mode = 2'd0; v = rnd_bytes(); tx_bytes = v; base = ngot; bb = nbrk;
    issue(2'd2, 6'd0, 2);
    fork
      wait_end(which, ticks, bbad, ce, rb);
      begin repeat (10) @(negedge clk); issue(2'd1, 6'h2A, 1); end
    join
    wait_ticks(3);
    chk(which == 2, "R10", "busy command leaves tx_done", which, 2);
    chk(nbrk == bb && ngot == base + 3, "R10", "no header from busy command", ngot - base, 3);
    bbad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || id_done) bbad++;
    end
    chk(bbad == 0, "R10", "no late header", bbad, 0);
    chk(stop_err == 0, "R2", "stop bits high", stop_err, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule